// File: doc/BRIEF.md
# Power-Management Switchback Wake Logic

This block sits beside the clock divider of a microcontroller core. While the core runs in its reduced-clock power-management state, the block watches a fixed set of peripheral and system events. Each event is gated by its own enable. When automatic switchback is allowed and any gated event fires, the block clears the power-management flag on the next clock edge, so the core returns to full-speed clocking. In that same cycle it raises a one-cycle switchback pulse.

The block holds the power-management flag itself. Software loads the flag through a write strobe and a data bit. Two kinds of input arrive differently:

- The serial receive line comes in asynchronously. It passes through a synchronizer and a falling-edge detector.
- All other event inputs are single-cycle strobes or levels already synchronous to the clock.

Top module: `pm_switchback_wake`

## Requirements
- R1: During and right after an active-low reset, `pm_mode` and `sb_pulse` are 0.
- R2: A cycle with `sw_pm_wr`=1 and no switchback clear loads `pm_mode` from `sw_pm_wdata` at the next edge. With no write and no clear, the flag holds.
- R3: External interrupt pin i counts as a wake event only when `ext_irq_evt[i]` and `ext_irq_en[i]` are both 1.
- R4: A high-to-low transition on `uart_rxd` is a wake event only when `uart_mode` is not 0 (serial modes 1, 2, 3) and `uart_rx_en`=1. The line passes two synchronizer flops and one edge flop. A low level first seen at edge k therefore clears the flag at edge k+2.
- R5: A receive line held low produces one wake event only. Setting the flag again while the line stays low leaves it set.
- R6: `uart_tx_wr` is a wake event only when `uart_tx_en`=1.
- R7: `spi_data_wr` is a wake event only when `spi_master`=1 and `spi_tx_en`=1.
- R8: Slave-select asserted (`spi_ssel_n`=0) while `spi_master`=0 is a wake event.
- R9: A debug breakpoint match or a debug-entry command each count as a wake event.
- R10: `pfail_evt` is a wake event only when `pfail_ie`=1.
- R11: With `sb_enable`=0, or with `pm_mode`=0, wake events leave `pm_mode` unchanged and raise no `sb_pulse`.
- R12: A software write of 1 in the same cycle as a qualifying wake event loses to the clear. The flag goes to 0 and a pulse is emitted.
- R13: `sb_pulse` is high for exactly the one cycle after the flag falls by switchback. It never coincides with `pm_mode`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sb_enable | input | 1 | Allows automatic switchback |
| sw_pm_wr | input | 1 | Software write strobe for the mode flag |
| sw_pm_wdata | input | 1 | Value written to the mode flag |
| ext_irq_evt | input | N_EXT | External interrupt condition per pin |
| ext_irq_en | input | N_EXT | External interrupt enable per pin |
| uart_rxd | input | 1 | Asynchronous serial receive line, idle high |
| uart_mode | input | 2 | Serial port mode (0..3) |
| uart_rx_en | input | 1 | Serial reception enable |
| uart_tx_wr | input | 1 | Write strobe to serial transmit data |
| uart_tx_en | input | 1 | Serial transmission enable |
| spi_data_wr | input | 1 | Write strobe to SPI data |
| spi_master | input | 1 | SPI master mode (1) or slave mode (0) |
| spi_tx_en | input | 1 | SPI transmission enable |
| spi_ssel_n | input | 1 | SPI slave select, active low, synchronous |
| dbg_bkpt_hit | input | 1 | Breakpoint match entering debug |
| dbg_cmd_enter | input | 1 | Debug command entering debug |
| pfail_evt | input | 1 | Power-fail condition |
| pfail_ie | input | 1 | Power-fail interrupt enable |
| pm_mode | output | 1 | Power-management mode flag |
| sb_pulse | output | 1 | One-cycle switchback pulse |

## Verification
The bench goes after these corner cases:

- **Enable gating.** An event is driven with its enable off, then on. A design that ignored an enable would drop back to full speed on stray peripheral activity.
- **Receive-line timing.** The receive line is checked in serial mode 0 and is also held low across a flag re-set. A wrong synchronizer depth shows up as an off-by-one clear cycle. A level-sensitive detector clears the flag again on every re-set.
- **Same-cycle write and wake.** A software write of 1 lands in the same cycle as a wake event. A design giving the write priority would stay slow and drop the pulse.
- **Switchback disabled or already at full speed.** Events arrive with switchback off and with the flag already clear. A missing qualification would emit spurious pulses.

// File: rtl/pm_sb_pkg.sv
// Package: shared wake-source indices and vector type for the switchback logic.
// Assumes: one bit per wake source class; external pins are OR-reduced first.
package pm_sb_pkg;
    typedef enum int unsigned {
        SRC_EXT  = 0,
        SRC_RXF  = 1,
        SRC_TXW  = 2,
        SRC_SPIW = 3,
        SRC_SSEL = 4,
        SRC_DBG  = 5,
        SRC_PF   = 6,
        SRC_NUM  = 7
    } wake_src_e;

    localparam int unsigned SRC_W = SRC_NUM;
    typedef logic [SRC_W-1:0] src_vec_t;
endpackage

// File: rtl/pm_sb_rx_edge.sv
// Module: synchronizes the asynchronous receive line and flags one cycle per
// high-to-low transition. Assumes the line idles high; reset fills chain with 1.
module pm_sb_rx_edge #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd_async,
    output logic rxd_fall
);
    localparam int unsigned LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // First synchronizer stage samples the raw line.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q[0] <= 1'b1;
        else        sync_q[0] <= rxd_async;
    end

    // Remaining synchronizer stages shift the sample along.
    generate
        for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[s] <= 1'b1;
                else        sync_q[s] <= sync_q[s-1];
            end
        end
    endgenerate

    // Edge flop holds the previous synchronized level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sync_q[LAST];
    end

    // Fall is high for one cycle when the synchronized level goes 1 -> 0.
    always_comb rxd_fall = prev_q & ~sync_q[LAST];
endmodule

// File: rtl/pm_sb_qualify.sv
// Module: gates each wake source with its own enable and ORs them.
// Assumes all inputs except the receive edge are synchronous to clk.
module pm_sb_qualify
    import pm_sb_pkg::*;
#(
    parameter int unsigned N_EXT  = 8,
    parameter int unsigned MODE_W = 2
) (
    input  logic [N_EXT-1:0]  ext_irq_evt,
    input  logic [N_EXT-1:0]  ext_irq_en,
    input  logic              rxd_fall,
    input  logic [MODE_W-1:0] uart_mode,
    input  logic              uart_rx_en,
    input  logic              uart_tx_wr,
    input  logic              uart_tx_en,
    input  logic              spi_data_wr,
    input  logic              spi_master,
    input  logic              spi_tx_en,
    input  logic              spi_ssel_n,
    input  logic              dbg_bkpt_hit,
    input  logic              dbg_cmd_enter,
    input  logic              pfail_evt,
    input  logic              pfail_ie,
    output src_vec_t          src_hit,
    output logic              wake_any
);
    logic [N_EXT-1:0] ext_hit;

    // One gate per external interrupt pin.
    generate
        for (genvar i = 0; i < N_EXT; i++) begin : g_ext
            assign ext_hit[i] = ext_irq_evt[i] & ext_irq_en[i];
        end
    endgenerate

    // Per-class qualification of every wake source.
    always_comb begin
        src_hit           = '0;
        src_hit[SRC_EXT]  = |ext_hit;
        src_hit[SRC_RXF]  = rxd_fall & uart_rx_en & (uart_mode != '0);
        src_hit[SRC_TXW]  = uart_tx_wr & uart_tx_en;
        src_hit[SRC_SPIW] = spi_data_wr & spi_master & spi_tx_en;
        src_hit[SRC_SSEL] = ~spi_ssel_n & ~spi_master;
        src_hit[SRC_DBG]  = dbg_bkpt_hit | dbg_cmd_enter;
        src_hit[SRC_PF]   = pfail_evt & pfail_ie;
    end

    // Any qualified source requests switchback.
    always_comb wake_any = |src_hit;
endmodule

// File: rtl/pm_sb_mode_reg.sv
// Module: holds the power-management flag and emits the switchback pulse.
// Assumes a switchback clear outranks a same-cycle software write.
module pm_sb_mode_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic sb_enable,
    input  logic wake_any,
    input  logic sw_pm_wr,
    input  logic sw_pm_wdata,
    output logic pm_mode,
    output logic sb_pulse
);
    logic do_clear;

    // Clear only when in power-management mode with switchback allowed.
    always_comb do_clear = pm_mode & sb_enable & wake_any;

    // Flag update: clear first, then software write, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)        pm_mode <= 1'b0;
        else if (do_clear) pm_mode <= 1'b0;
        else if (sw_pm_wr) pm_mode <= sw_pm_wdata;
    end

    // Pulse marks the cycle after a switchback clear.
    always_ff @(posedge clk) begin
        if (!rst_n) sb_pulse <= 1'b0;
        else        sb_pulse <= do_clear;
    end
endmodule

// File: rtl/pm_switchback_wake.sv
// Top: automatic return from reduced-clock mode on qualified wake events.
// Assumes synchronous active-low reset; uart_rxd is the only async input.
module pm_switchback_wake
    import pm_sb_pkg::*;
#(
    parameter int unsigned N_EXT       = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned MODE_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sb_enable,
    input  logic              sw_pm_wr,
    input  logic              sw_pm_wdata,
    input  logic [N_EXT-1:0]  ext_irq_evt,
    input  logic [N_EXT-1:0]  ext_irq_en,
    input  logic              uart_rxd,
    input  logic [MODE_W-1:0] uart_mode,
    input  logic              uart_rx_en,
    input  logic              uart_tx_wr,
    input  logic              uart_tx_en,
    input  logic              spi_data_wr,
    input  logic              spi_master,
    input  logic              spi_tx_en,
    input  logic              spi_ssel_n,
    input  logic              dbg_bkpt_hit,
    input  logic              dbg_cmd_enter,
    input  logic              pfail_evt,
    input  logic              pfail_ie,
    output logic              pm_mode,
    output logic              sb_pulse
);
    logic     rxd_fall;
    logic     wake_any;
    src_vec_t src_hit;

    pm_sb_rx_edge #(.SYNC_STAGES(SYNC_STAGES)) u_rx_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .rxd_async (uart_rxd),
        .rxd_fall  (rxd_fall)
    );

    pm_sb_qualify #(.N_EXT(N_EXT), .MODE_W(MODE_W)) u_qualify (
        .ext_irq_evt   (ext_irq_evt),
        .ext_irq_en    (ext_irq_en),
        .rxd_fall      (rxd_fall),
        .uart_mode     (uart_mode),
        .uart_rx_en    (uart_rx_en),
        .uart_tx_wr    (uart_tx_wr),
        .uart_tx_en    (uart_tx_en),
        .spi_data_wr   (spi_data_wr),
        .spi_master    (spi_master),
        .spi_tx_en     (spi_tx_en),
        .spi_ssel_n    (spi_ssel_n),
        .dbg_bkpt_hit  (dbg_bkpt_hit),
        .dbg_cmd_enter (dbg_cmd_enter),
        .pfail_evt     (pfail_evt),
        .pfail_ie      (pfail_ie),
        .src_hit       (src_hit),
        .wake_any      (wake_any)
    );

    pm_sb_mode_reg u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .sb_enable   (sb_enable),
        .wake_any    (wake_any),
        .sw_pm_wr    (sw_pm_wr),
        .sw_pm_wdata (sw_pm_wdata),
        .pm_mode     (pm_mode),
        .sb_pulse    (sb_pulse)
    );
endmodule

// File: rtl/pm_sb_checker.sv
// Checker: temporal properties of the switchback flag and pulse.
module pm_sb_checker (
    input logic clk,
    input logic rst_n,
    input logic sb_enable,
    input logic wake_any,
    input logic pfail_evt,
    input logic pfail_ie,
    input logic pm_mode,
    input logic sb_pulse
);
    // R1: reset drives both outputs low.
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (!pm_mode && !sb_pulse));

    // R11: with switchback disabled no pulse follows.
    assert_disabled_no_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !sb_enable |=> !sb_pulse);

    // R12: a qualified wake in power-management mode always clears.
    assert_clear_priority_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_mode && sb_enable && wake_any) |=> (!pm_mode && sb_pulse));

    // R13: pulse only when the flag has just fallen.
    assert_pulse_on_fall_R13: assert property (@(posedge clk) disable iff (!rst_n)
        sb_pulse |-> (!pm_mode && $past(pm_mode)));

    // R13: pulse is one cycle wide.
    assert_pulse_single_R13: assert property (@(posedge clk) disable iff (!rst_n)
        sb_pulse |=> !sb_pulse);

    // R10: enabled power-fail wakes the core.
    assert_pfail_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_mode && sb_enable && pfail_evt && pfail_ie) |=> sb_pulse);
endmodule

bind pm_switchback_wake pm_sb_checker u_chk (.*);

// File: tb/pm_switchback_wake_test.sv
`timescale 1ns/1ps
module pm_switchback_wake_test;
    localparam int N_EXT = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sb_enable, sw_pm_wr, sw_pm_wdata;
    logic [N_EXT-1:0] ext_irq_evt, ext_irq_en;
    logic uart_rxd;
    logic [1:0] uart_mode;
    logic uart_rx_en, uart_tx_wr, uart_tx_en;
    logic spi_data_wr, spi_master, spi_tx_en, spi_ssel_n;
    logic dbg_bkpt_hit, dbg_cmd_enter, pfail_evt, pfail_ie;
    logic pm_mode, sb_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Bench reference state
    logic m_pm, m_pulse, m_r1, m_r2, m_r3;

    always #2 clk = ~clk;

    pm_switchback_wake #(.N_EXT(N_EXT)) uut (.*);

    task automatic check(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic wake_exp(logic fall);
        return (|(ext_irq_evt & ext_irq_en))
             | (fall & uart_rx_en & (uart_mode != 2'd0))
             | (uart_tx_wr & uart_tx_en)
             | (spi_data_wr & spi_master & spi_tx_en)
             | (~spi_ssel_n & ~spi_master)
             | dbg_bkpt_hit | dbg_cmd_enter
             | (pfail_evt & pfail_ie);
    endfunction

    task automatic defaults();
        sw_pm_wr = 0; sw_pm_wdata = 0;
        ext_irq_evt = '0; uart_tx_wr = 0; spi_data_wr = 0;
        dbg_bkpt_hit = 0; dbg_cmd_enter = 0; pfail_evt = 0;
        spi_ssel_n = 1;
    endtask

    // Called at a negedge with inputs set; advances one cycle and compares.
    task automatic step(string tag);
        logic fall, w;
        fall = m_r3 & ~m_r2;
        w = wake_exp(fall);
        if (m_pm && sb_enable && w) begin
            m_pm = 0; m_pulse = 1;
        end else begin
            m_pulse = 0;
            if (sw_pm_wr) m_pm = sw_pm_wdata;
        end
        m_r3 = m_r2; m_r2 = m_r1; m_r1 = uart_rxd;
        @(negedge clk);
        check(tag, "pm_mode", pm_mode, m_pm);
        check(tag, "sb_pulse", sb_pulse, m_pulse);
    endtask

    task automatic set_pm(string tag);
        defaults(); sw_pm_wr = 1; sw_pm_wdata = 1;
        step(tag);
        defaults();
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        defaults();
        sb_enable = 1; ext_irq_en = '0; uart_rxd = 1; uart_mode = 0;
        uart_rx_en = 0; uart_tx_en = 0; spi_master = 0; spi_tx_en = 0; pfail_ie = 0;
        m_pm = 0; m_pulse = 0; m_r1 = 1; m_r2 = 1; m_r3 = 1;
        repeat (3) @(negedge clk);
        check("R1", "pm_mode", pm_mode, 1'b0);
        check("R1", "sb_pulse", sb_pulse, 1'b0);
        rst_n = 1;
        // R2: load and hold
        set_pm("R2");
        step("R2");
        // R3: per-pin enable
        ext_irq_evt = 8'h02; ext_irq_en = 8'h01; step("R3"); defaults();
        ext_irq_evt = 8'h02; ext_irq_en = 8'h02; step("R3"); defaults();
        step("R13");
        ext_irq_en = '0;
        // R4: mode 0 ignores receive edge
        set_pm("R4");
        uart_rx_en = 1; uart_mode = 0; uart_rxd = 0;
        repeat (4) step("R4");
        uart_rxd = 1; repeat (3) step("R4");
        uart_mode = 2; uart_rxd = 0;
        repeat (4) step("R4");
        // R5: held low does not retrigger
        set_pm("R5");
        repeat (5) step("R5");
        uart_rxd = 1; uart_mode = 0; uart_rx_en = 0;
        repeat (3) step("R5");
        // R6
        set_pm("R6");
        uart_tx_wr = 1; uart_tx_en = 0; step("R6"); defaults();
        uart_tx_wr = 1; uart_tx_en = 1; step("R6"); defaults();
        uart_tx_en = 0;
        // R7
        set_pm("R7");
        spi_data_wr = 1; spi_master = 0; spi_tx_en = 1; spi_ssel_n = 1; step("R7"); defaults();
        spi_data_wr = 1; spi_master = 1; spi_tx_en = 0; step("R7"); defaults();
        spi_data_wr = 1; spi_master = 1; spi_tx_en = 1; step("R7"); defaults();
        // R8
        set_pm("R8");
        spi_master = 1; spi_ssel_n = 0; step("R8"); defaults();
        spi_master = 0; spi_ssel_n = 0; step("R8"); defaults();
        spi_tx_en = 0;
        // R9
        set_pm("R9"); dbg_bkpt_hit = 1; step("R9"); defaults();
        set_pm("R9"); dbg_cmd_enter = 1; step("R9"); defaults();
        // R10
        set_pm("R10");
        pfail_evt = 1; pfail_ie = 0; step("R10"); defaults();
        pfail_evt = 1; pfail_ie = 1; step("R10"); defaults();
        pfail_ie = 0;
        // R11: disabled, then normal mode
        set_pm("R11");
        sb_enable = 0; dbg_bkpt_hit = 1; step("R11"); defaults();
        sb_enable = 1; sw_pm_wr = 1; sw_pm_wdata = 0; step("R11"); defaults();
        pfail_evt = 1; pfail_ie = 1; step("R11"); defaults();
        pfail_ie = 0;
        // R12: clear beats same-cycle set
        set_pm("R12");
        sw_pm_wr = 1; sw_pm_wdata = 1; dbg_cmd_enter = 1; step("R12"); defaults();
        step("R12");
        // Random phase, all requirements cross-checked by the reference model
        for (int n = 0; n < 4000; n++) begin
            sb_enable     = ($urandom % 8) != 0;
            sw_pm_wr      = ($urandom % 6) == 0;
            sw_pm_wdata   = ($urandom % 4) != 0;
            ext_irq_evt   = (($urandom % 16) == 0) ? 8'($urandom) : '0;
            ext_irq_en    = 8'($urandom);
            if (($urandom % 10) == 0) uart_rxd = ~uart_rxd;
            uart_mode     = 2'($urandom);
            uart_rx_en    = 1'($urandom);
            uart_tx_wr    = ($urandom % 16) == 0;
            uart_tx_en    = 1'($urandom);
            spi_data_wr   = ($urandom % 16) == 0;
            spi_master    = ($urandom % 4) != 0;
            spi_tx_en     = 1'($urandom);
            spi_ssel_n    = ($urandom % 12) != 0;
            dbg_bkpt_hit  = ($urandom % 40) == 0;
            dbg_cmd_enter = ($urandom % 40) == 0;
            pfail_evt     = ($urandom % 20) == 0;
            pfail_ie      = 1'($urandom);
            step("R13");
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule